// File: doc/BRIEF.md
# LPI Pending Bit Update Unit

This unit applies single-interrupt set and clear requests, coming from an interrupt translation stage, to a pending bitmap held in memory. Each legal request starts a byte read-modify-write. The byte's address is the pending-table base plus the interrupt ID divided by eight. The addressed bit is replaced with the requested level, and the byte is written back only when the bit actually changes.

The unit also keeps a cached copy of the best pending interrupt: its ID, its priority and a valid flag. When a bit is newly set, the unit looks up that interrupt's priority and updates the cache in place when the new interrupt wins. When the cached interrupt itself is cleared, the unit invalidates the cache and asks an external scan engine for a full rescan. The scan result is then loaded into the cache. At the end of every legal request, the unit pulses an update strobe so that the interrupt output state can be re-evaluated.

Requests are rejected before any memory access in three cases: the ID is below the first LPI ID (8192), the ID exceeds the range set by the configured ID width, or the configuration is not usable.

Top module: `lpi_pend_updater`

## Requirements
- R1: A request whose ID is below 8192 is consumed without effect: no memory read, no write, no update pulse, and `req_ready` stays high. An ID of exactly 8192 is processed.
- R2: With ID-width field `n`, IDs up to 2^(n+1)-1 are processed and any larger ID is dropped like R1. When n+1 is at least the ID width, no upper limit applies.
- R3: Every request is dropped like R1 when `cfg_lpi_en` is low, or when `cfg_prop_base` or `cfg_pend_base` is zero.
- R4: A legal request reads address `cfg_pend_base + ID/8`. Read data is taken in the cycle after `mem_rd_en`. The bit examined is bit ID%8 of that byte, where bit 0 is the LSB.
- R5: If the examined bit already equals the requested level, the request ends with no write, no priority lookup and no rescan request.
- R6: Otherwise exactly one write goes to the same address. The written byte equals the read byte with only bit ID%8 replaced by the level.
- R7: A set that changes the bit issues one priority lookup, where a lower value means higher priority. The cache takes the new ID and priority if the cache is empty or the new priority is strictly lower; on equal or higher values it is unchanged.
- R8: A clear that changes the bit of the cached ID invalidates the cache and pulses `rescan_req` for one cycle. When `rescan_done` arrives, the cache loads `rescan_found`, `rescan_id` and `rescan_prio`. A clear of any other ID requests no rescan.
- R9: Every legal request produces exactly one one-cycle `irq_update` pulse, in its last cycle. Dropped requests produce none.
- R10: After reset `req_ready` is high, the cache is empty and all strobes are low. `req_ready` stays low from the acceptance of a legal request until it has completed, including any lookup or rescan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lpi_en | input | 1 | LPI processing enable |
| cfg_prop_base | input | AW | Property table base; zero means unusable |
| cfg_pend_base | input | AW | Pending table byte base address |
| cfg_idbits | input | IDB_W | ID width field n; max ID is 2^(n+1)-1 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit idle and able to accept |
| req_id | input | ID_W | Interrupt ID |
| req_level | input | 1 | 1 = set pending, 0 = clear |
| mem_rd_en | output | 1 | Byte read strobe |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_addr | output | AW | Byte address for read and write |
| mem_rd_data | input | 8 | Read data, valid the cycle after mem_rd_en |
| mem_wr_data | output | 8 | Write data |
| prio_req | output | 1 | Priority lookup request, one cycle |
| prio_id | output | ID_W | ID being looked up |
| prio_rsp_valid | input | 1 | Lookup result valid |
| prio_rsp | input | PRIO_W | Looked-up priority |
| rescan_req | output | 1 | One-cycle request for a full table scan |
| rescan_done | input | 1 | Scan finished, result valid |
| rescan_found | input | 1 | Scan found a pending interrupt |
| rescan_id | input | ID_W | Best ID found by the scan |
| rescan_prio | input | PRIO_W | Priority of that ID |
| best_valid | output | 1 | Cache holds an interrupt |
| best_id | output | ID_W | Cached best ID |
| best_prio | output | PRIO_W | Cached best priority |
| irq_update | output | 1 | One-cycle pulse at the end of a legal request |

## Verification
The bench probes the range edges: 8191 against 8192, and 2^(n+1)-1 against 2^(n+1). An off-by-one in either compare would touch memory for an ID that should be ignored, or would silently drop a legal one. Preloading a byte with unrelated set bits shows whether the write-back keeps its neighbours. A wrong mask or bit index would erase other pending interrupts. Re-sending a level that already holds exposes a unit that writes or looks up anyway.

A priority equal to the cached one exposes a compare that uses "less or equal" and steals the cache. Clearing a non-cached ID, and then clearing the cached one, shows whether rescans are requested only when needed. A rescan that returns nothing shows whether the cache is correctly left empty, and whether the next set takes it.

// File: rtl/lpi_pend_pkg.sv
package lpi_pend_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_SEL_W = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_READ,
    ST_MODIFY,
    ST_WRITE,
    ST_PRIO_ASK,
    ST_PRIO_WAIT,
    ST_SCAN_ASK,
    ST_SCAN_WAIT,
    ST_FINISH
  } upd_state_e;

endpackage

// File: rtl/lpi_req_filter.sv
module lpi_req_filter #(
  parameter int ID_W      = 16,
  parameter int AW        = 32,
  parameter int IDB_W     = 5,
  parameter int FIRST_LPI = 8192
) (
  input  logic             lpi_en,
  input  logic [AW-1:0]    prop_base,
  input  logic [AW-1:0]    pend_base,
  input  logic [IDB_W-1:0] idbits,
  input  logic [ID_W-1:0]  id,
  output logic             legal
);

  localparam int SHW = IDB_W + 1;
  localparam logic [SHW-1:0] ID_W_S = SHW'(ID_W);
  localparam logic [ID_W-1:0] FIRST_S = ID_W'(FIRST_LPI);

  logic [SHW-1:0] span;
  logic           cfg_ok;
  logic           low_ok;
  logic           high_ok;

  always_comb begin
    span    = {1'b0, idbits} + SHW'(1);
    cfg_ok  = lpi_en && (prop_base != '0) && (pend_base != '0);
    low_ok  = (id >= FIRST_S);
    high_ok = (span >= ID_W_S) || ((id >> span) == '0);
    legal   = cfg_ok && low_ok && high_ok;
  end

endmodule

// File: rtl/lpi_bit_merge.sv
module lpi_bit_merge
  import lpi_pend_pkg::*;
(
  input  logic [BYTE_W-1:0]    old_byte,
  input  logic [BIT_SEL_W-1:0] sel,
  input  logic                 level,
  output logic [BYTE_W-1:0]    new_byte,
  output logic                 cur_bit
);

  for (genvar b = 0; b < BYTE_W; b++) begin : g_lane
    assign new_byte[b] = (sel == BIT_SEL_W'(b)) ? level : old_byte[b];
  end

  assign cur_bit = old_byte[sel];

endmodule

// File: rtl/lpi_best_cache.sv
module lpi_best_cache #(
  parameter int ID_W   = 16,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cand_load,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              inval,
  input  logic              scan_load,
  input  logic              scan_found,
  input  logic [ID_W-1:0]   scan_id,
  input  logic [PRIO_W-1:0] scan_prio,
  output logic              valid,
  output logic [ID_W-1:0]   id,
  output logic [PRIO_W-1:0] prio
);

  logic wins;

  assign wins = !valid || (cand_prio < prio);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      id    <= '0;
      prio  <= '1;
    end else if (scan_load) begin
      valid <= scan_found;
      id    <= scan_id;
      prio  <= scan_found ? scan_prio : '1;
    end else if (inval) begin
      valid <= 1'b0;
      prio  <= '1;
    end else if (cand_load && wins) begin
      valid <= 1'b1;
      id    <= cand_id;
      prio  <= cand_prio;
    end
  end

endmodule

// File: rtl/lpi_pend_updater.sv
module lpi_pend_updater
  import lpi_pend_pkg::*;
#(
  parameter int ID_W      = 16,
  parameter int PRIO_W    = 8,
  parameter int AW        = 32,
  parameter int IDB_W     = 5,
  parameter int FIRST_LPI = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_lpi_en,
  input  logic [AW-1:0]     cfg_prop_base,
  input  logic [AW-1:0]     cfg_pend_base,
  input  logic [IDB_W-1:0]  cfg_idbits,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_level,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [AW-1:0]     mem_addr,
  input  logic [7:0]        mem_rd_data,
  output logic [7:0]        mem_wr_data,
  output logic              prio_req,
  output logic [ID_W-1:0]   prio_id,
  input  logic              prio_rsp_valid,
  input  logic [PRIO_W-1:0] prio_rsp,
  output logic              rescan_req,
  input  logic              rescan_done,
  input  logic              rescan_found,
  input  logic [ID_W-1:0]   rescan_id,
  input  logic [PRIO_W-1:0] rescan_prio,
  output logic              best_valid,
  output logic [ID_W-1:0]   best_id,
  output logic [PRIO_W-1:0] best_prio,
  output logic              irq_update
);

  upd_state_e            state;
  logic [ID_W-1:0]       id_q;
  logic                  lvl_q;
  logic [AW-1:0]         addr_q;
  logic [BYTE_W-1:0]     wdata_q;
  logic                  legal;
  logic [BYTE_W-1:0]     merged;
  logic                  cur_bit;
  logic                  hit_best;

  lpi_req_filter #(
    .ID_W(ID_W), .AW(AW), .IDB_W(IDB_W), .FIRST_LPI(FIRST_LPI)
  ) u_filter (
    .lpi_en    (cfg_lpi_en),
    .prop_base (cfg_prop_base),
    .pend_base (cfg_pend_base),
    .idbits    (cfg_idbits),
    .id        (req_id),
    .legal     (legal)
  );

  lpi_bit_merge u_merge (
    .old_byte (mem_rd_data),
    .sel      (id_q[BIT_SEL_W-1:0]),
    .level    (lvl_q),
    .new_byte (merged),
    .cur_bit  (cur_bit)
  );

  assign hit_best = best_valid && (best_id == id_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      id_q    <= '0;
      lvl_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid && legal) begin
            id_q   <= req_id;
            lvl_q  <= req_level;
            addr_q <= cfg_pend_base + AW'(req_id >> BIT_SEL_W);
            state  <= ST_READ;
          end
        end
        ST_READ:   state <= ST_MODIFY;
        ST_MODIFY: begin
          if (cur_bit == lvl_q) begin
            state <= ST_FINISH;
          end else begin
            wdata_q <= merged;
            state   <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (lvl_q)         state <= ST_PRIO_ASK;
          else if (hit_best) state <= ST_SCAN_ASK;
          else               state <= ST_FINISH;
        end
        ST_PRIO_ASK:  state <= ST_PRIO_WAIT;
        ST_PRIO_WAIT: if (prio_rsp_valid) state <= ST_FINISH;
        ST_SCAN_ASK:  state <= ST_SCAN_WAIT;
        ST_SCAN_WAIT: if (rescan_done) state <= ST_FINISH;
        ST_FINISH:    state <= ST_IDLE;
        default:      state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign mem_rd_en   = (state == ST_READ);
  assign mem_wr_en   = (state == ST_WRITE);
  assign mem_addr    = addr_q;
  assign mem_wr_data = wdata_q;
  assign prio_req    = (state == ST_PRIO_ASK);
  assign prio_id     = id_q;
  assign rescan_req  = (state == ST_SCAN_ASK);
  assign irq_update  = (state == ST_FINISH);

  lpi_best_cache #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_cache (
    .clk        (clk),
    .rst        (rst),
    .cand_load  ((state == ST_PRIO_WAIT) && prio_rsp_valid),
    .cand_id    (id_q),
    .cand_prio  (prio_rsp),
    .inval      ((state == ST_WRITE) && !lvl_q && hit_best),
    .scan_load  ((state == ST_SCAN_WAIT) && rescan_done),
    .scan_found (rescan_found),
    .scan_id    (rescan_id),
    .scan_prio  (rescan_prio),
    .valid      (best_valid),
    .id         (best_id),
    .prio       (best_prio)
  );

endmodule

// File: rtl/lpi_pend_updater_chk.sv
module lpi_pend_updater_chk #(
  parameter int ID_W      = 16,
  parameter int AW        = 32,
  parameter int FIRST_LPI = 8192
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [ID_W-1:0] req_id,
  input logic            mem_rd_en,
  input logic            mem_wr_en,
  input logic [AW-1:0]   mem_addr,
  input logic            prio_req,
  input logic            rescan_req,
  input logic            irq_update
);

  // R1: a low ID leaves the unit idle with no read
  p_low_id_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_id < ID_W'(FIRST_LPI))) |=> (req_ready && !mem_rd_en));

  // R4: the byte is examined before any write is issued
  p_read_before_write_r4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_wr_en);

  // R6: the write goes to the address that was read
  p_write_same_addr_r6: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> $stable(mem_addr));

  // R8: rescan request is a single-cycle pulse
  p_rescan_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rescan_req |=> !rescan_req);

  // R9: the update pulse is the last busy cycle
  p_update_last_r9: assert property (@(posedge clk) disable iff (rst)
    irq_update |=> req_ready);

  // R10: no new request is taken while work is in flight
  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en || mem_wr_en || prio_req || rescan_req || irq_update) |-> !req_ready);

endmodule

bind lpi_pend_updater lpi_pend_updater_chk #(
  .ID_W(ID_W), .AW(AW), .FIRST_LPI(FIRST_LPI)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_id     (req_id),
  .mem_rd_en  (mem_rd_en),
  .mem_wr_en  (mem_wr_en),
  .mem_addr   (mem_addr),
  .prio_req   (prio_req),
  .rescan_req (rescan_req),
  .irq_update (irq_update)
);

// File: tb/lpi_pend_updater_tb.sv
module lpi_pend_updater_tb;

  localparam int ID_W = 16;
  localparam int PRIO_W = 8;
  localparam int AW = 32;
  localparam int IDB_W = 5;
  localparam int MEM_BYTES = 8192;
  localparam logic [AW-1:0] PBASE = 32'h0001_0000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_lpi_en = 1'b1;
  logic [AW-1:0]     cfg_prop_base = 32'h0000_2000;
  logic [AW-1:0]     cfg_pend_base = PBASE;
  logic [IDB_W-1:0]  cfg_idbits = 5'd15;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ID_W-1:0]   req_id = '0;
  logic              req_level = 1'b0;
  logic              mem_rd_en, mem_wr_en;
  logic [AW-1:0]     mem_addr;
  logic [7:0]        mem_rd_data;
  logic [7:0]        mem_wr_data;
  logic              prio_req;
  logic [ID_W-1:0]   prio_id;
  logic              prio_rsp_valid;
  logic [PRIO_W-1:0] prio_rsp;
  logic              rescan_req;
  logic              rescan_done;
  logic              rs_found = 1'b0;
  logic [ID_W-1:0]   rs_id = '0;
  logic [PRIO_W-1:0] rs_prio = '0;
  logic              best_valid;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_prio;
  logic              irq_update;

  always #2 clk = ~clk;

  lpi_pend_updater u_dut (
    .clk(clk), .rst(rst),
    .cfg_lpi_en(cfg_lpi_en), .cfg_prop_base(cfg_prop_base),
    .cfg_pend_base(cfg_pend_base), .cfg_idbits(cfg_idbits),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_level(req_level),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_data(mem_wr_data),
    .prio_req(prio_req), .prio_id(prio_id), .prio_rsp_valid(prio_rsp_valid), .prio_rsp(prio_rsp),
    .rescan_req(rescan_req), .rescan_done(rescan_done), .rescan_found(rs_found),
    .rescan_id(rs_id), .rescan_prio(rs_prio),
    .best_valid(best_valid), .best_id(best_id), .best_prio(best_prio),
    .irq_update(irq_update)
  );

  // ---------------- models ----------------
  logic [7:0] mem [MEM_BYTES];
  logic [AW-1:0] last_wr_addr;

  function automatic logic [PRIO_W-1:0] pf(input int id);
    return PRIO_W'((id * 7) % 256);
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[int'(mem_addr - PBASE) % MEM_BYTES];
    if (mem_wr_en) begin
      mem[int'(mem_addr - PBASE) % MEM_BYTES] <= mem_wr_data;
      last_wr_addr <= mem_addr;
    end
  end

  always @(posedge clk) begin
    prio_rsp_valid <= prio_req && !rst;
    prio_rsp       <= pf(int'(prio_id));
  end

  logic       rs_busy;
  logic [1:0] rs_cnt;
  always @(posedge clk) begin
    if (rst) begin
      rs_busy <= 1'b0; rs_cnt <= '0; rescan_done <= 1'b0;
    end else begin
      rescan_done <= 1'b0;
      if (rescan_req) begin
        rs_busy <= 1'b1; rs_cnt <= 2'd2;
      end else if (rs_busy) begin
        if (rs_cnt == 0) begin rescan_done <= 1'b1; rs_busy <= 1'b0; end
        else rs_cnt <= rs_cnt - 2'd1;
      end
    end
  end

  int n_rd = 0, n_wr = 0, n_pq = 0, n_rs = 0, n_up = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd_en)  n_rd++;
      if (mem_wr_en)  n_wr++;
      if (prio_req)   n_pq++;
      if (rescan_req) n_rs++;
      if (irq_update) n_up++;
    end
  end

  // expected cache
  bit              m_valid = 1'b0;
  int              m_id = 0;
  int              m_prio = 255;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic send(input int id, input bit lvl, input bit acc, input string rq);
    int off = id / 8;
    int bi = id % 8;
    logic [7:0] old, expb;
    int rd0 = n_rd, wr0 = n_wr, pq0 = n_pq, rs0 = n_rs, up0 = n_up;
    bit chg, hit;
    old = mem[off % MEM_BYTES];
    @(negedge clk);
    req_valid = 1'b1; req_id = ID_W'(id); req_level = lvl;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == !acc, acc ? "R10" : rq, "ready after request", int'(req_ready), int'(!acc));
    for (int k = 0; k < 60 && !req_ready; k++) @(negedge clk);
    @(negedge clk);
    chg = acc && (old[bi] != lvl);
    hit = chg && !lvl && m_valid && (m_id == id);
    expb = old;
    if (chg) expb[bi] = lvl;
    chk(n_rd - rd0 == int'(acc), rq, "reads", n_rd - rd0, int'(acc));
    chk(n_wr - wr0 == int'(chg), chg ? "R6" : (acc ? "R5" : rq), "writes", n_wr - wr0, int'(chg));
    chk(n_pq - pq0 == int'(chg && lvl), "R7", "lookups", n_pq - pq0, int'(chg && lvl));
    chk(n_rs - rs0 == int'(hit), "R8", "rescans", n_rs - rs0, int'(hit));
    chk(n_up - up0 == int'(acc), "R9", "update pulses", n_up - up0, int'(acc));
    if (acc) chk(mem[off % MEM_BYTES] == expb, "R6", "byte after update", int'(mem[off % MEM_BYTES]), int'(expb));
    if (chg) chk(last_wr_addr == PBASE + AW'(off), "R4", "write address", int'(last_wr_addr), int'(PBASE) + off);
    if (chg && lvl) begin
      if (!m_valid || int'(pf(id)) < m_prio) begin
        m_valid = 1'b1; m_id = id; m_prio = int'(pf(id));
      end
    end
    if (hit) begin
      m_valid = rs_found; m_id = int'(rs_id); m_prio = rs_found ? int'(rs_prio) : 255;
    end
    chk(best_valid == m_valid, (hit ? "R8" : "R7"), "best_valid", int'(best_valid), int'(m_valid));
    if (m_valid) begin
      chk(int'(best_id) == m_id, (hit ? "R8" : "R7"), "best_id", int'(best_id), m_id);
      chk(int'(best_prio) == m_prio, (hit ? "R8" : "R7"), "best_prio", int'(best_prio), m_prio);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(req_ready == 1'b1, "R10", "ready after reset", int'(req_ready), 1);
    chk(best_valid == 1'b0, "R10", "cache empty after reset", int'(best_valid), 0);
    chk(!(mem_rd_en || mem_wr_en || prio_req || rescan_req || irq_update), "R10",
        "strobes idle after reset", int'(mem_rd_en | mem_wr_en | prio_req | rescan_req | irq_update), 0);
  endtask

  task automatic t_range();
    cfg_idbits = 5'd13;
    send(16384, 1'b1, 1'b0, "R2");
    send(16383, 1'b1, 1'b1, "R2");
    cfg_idbits = 5'd15;
    send(65535, 1'b1, 1'b1, "R2");
  endtask

  task automatic t_set_order();
    send(8200, 1'b1, 1'b1, "R7");
    send(8203, 1'b1, 1'b1, "R7");
    send(8456, 1'b1, 1'b1, "R7");
    send(8193, 1'b1, 1'b1, "R7");
  endtask

  task automatic t_same_level();
    send(8200, 1'b1, 1'b1, "R5");
    send(8300, 1'b0, 1'b1, "R5");
  endtask

  task automatic t_clear_paths();
    send(8203, 1'b0, 1'b1, "R8");
    send(8203, 1'b0, 1'b1, "R5");
    rs_found = 1'b1; rs_id = 16'd8200; rs_prio = pf(8200);
    send(8193, 1'b0, 1'b1, "R8");
  endtask

  task automatic t_rescan_empty();
    rs_found = 1'b0; rs_id = '0; rs_prio = '0;
    send(8200, 1'b0, 1'b1, "R8");
    send(8210, 1'b1, 1'b1, "R7");
  endtask

  task automatic t_disabled();
    cfg_lpi_en = 1'b0;
    send(8400, 1'b1, 1'b0, "R3");
    cfg_lpi_en = 1'b1; cfg_prop_base = '0;
    send(8400, 1'b1, 1'b0, "R3");
    cfg_prop_base = 32'h0000_2000; cfg_pend_base = '0;
    send(8400, 1'b1, 1'b0, "R3");
    cfg_pend_base = PBASE;
  endtask

  task automatic t_low_id();
    send(8191, 1'b1, 1'b0, "R1");
    send(0, 1'b1, 1'b0, "R1");
    send(8192, 1'b1, 1'b1, "R1");
  endtask

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'h00;
    mem[1025] = 8'hA4;
    mem[1037] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_range();
    t_set_order();
    t_same_level();
    t_clear_paths();
    t_rescan_empty();
    t_disabled();
    t_low_id();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule